// File: doc/BRIEF.md
# Direct-Mapped Write-Through Byte Cache

The block is a direct-mapped cache between a byte-wide CPU request port and a byte-wide main-memory port. It splits the byte address into three fields. The middle field picks exactly one line, and that line's stored tag and valid flag decide whether the access hits. Because every block has exactly one home line, there is no replacement choice. A block that lands on an occupied line simply displaces the line's previous contents.

Reads that hit return their byte in one clock. A read miss fetches the whole line from memory one byte at a time, lowest offset first. It then installs the line and returns the requested byte. Every write is passed to memory. A write that hits also patches the cached byte. A write that misses leaves the cache untouched.

The CPU port is a request handshake. The CPU raises `req_valid` with `req_write`, `req_addr` and `req_wdata` and holds all four steady until it sees `req_ready`. `req_ready` is a one-cycle completion pulse, and `rsp_rdata` is meaningful during that pulse for reads. The block ignores `req_valid` while the pulse is high, so the CPU may drop the request or present the next one in the following cycle. The memory port is the mirror image. The block holds `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` steady until memory returns a one-cycle `mem_ready`, with `mem_rdata` valid in that cycle. Memory may stretch any transfer by holding `mem_ready` low.

Top module: `dm_wt_cache`

## Requirements
- R1: Address bits [19:13] are the tag, bits [12:3] the line index and bits [2:0] the byte offset. Address 0xABCDE therefore maps to line 0x39B, offset 6, tag 0x55, and its miss fetches bytes 0xABCD8 through 0xABCDF.
- R2: After reset no line is valid. `req_ready` and `mem_valid` are low, and the first read of any address misses.
- R3: A read miss issues exactly eight memory reads (`mem_write`=0) at offsets 0 to 7 of the block, in ascending order. It then returns the byte that memory holds at the requested address.
- R4: A read hit raises `req_ready` in the clock after the request is first presented. It issues no memory transfer and returns the cached byte.
- R5: A block whose index matches a valid line but whose tag differs misses and replaces that line. A later read of the displaced block misses again.
- R6: Every write issues exactly one memory write with the request's address and data. `req_ready` rises only after that transfer completes.
- R7: A write hit updates the cached byte. A later read of that address hits and returns the new byte without a memory transfer.
- R8: A write miss allocates no line. A later read of that address misses and fetches the line, which includes the written byte.
- R9: `req_ready` is high for exactly one cycle per request. While `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with `req_ready` |
| mem_valid | output | 1 | Memory transfer requested |
| mem_write | output | 1 | 1 = memory write |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory completes transfer this cycle |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ready` |

## Verification
The bench builds the block with its default parameters: a 20-bit address, 1024 lines and 8-byte lines. This lets it check the 0xABCDE field split exactly. It reaches index conflicts by choosing a second tag for line 0x39B. The memory model stretches transfers by 0 to 2 cycles in rotation, so the hold rules on the memory port are exercised during both fills and writes. A scoreboard compares every returned read byte with a bench-side memory image that tracks each write.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int TAG_W = 7,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             inst_en,
  output logic             hit
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  assign hit = valid_q[idx] && (tag_q[idx] == tag);

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (inst_en) valid_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[idx] <= tag;
  end

  // R3: a line installed by a fill is valid in the next cycle
  p_install_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en |=> valid_q[$past(idx)]);
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 3
) (
  input  logic                     clk,
  input  logic [IDX_W-1:0]         idx,
  input  logic [OFF_W-1:0]         off,
  output logic [7:0]               rd_byte,
  input  logic                     bw_en,
  input  logic [7:0]               bw_data,
  input  logic                     lw_en,
  input  logic [(8<<OFF_W)-1:0]    lw_data
);
  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = 8 << OFF_W;

  logic [LINE_W-1:0] line_q [LINES];

  assign rd_byte = line_q[idx][{off, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (lw_en) line_q[idx] <= lw_data;
    else if (bw_en) line_q[idx][{off, 3'b000} +: 8] <= bw_data;
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [7:0]            req_wdata,
  output logic                  req_ready,
  output logic [7:0]            rsp_rdata,
  output logic                  mem_valid,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [7:0]            mem_wdata,
  input  logic                  mem_ready,
  input  logic [7:0]            mem_rdata,
  output logic [ADDR_W-1:0]     lk_addr,
  input  logic                  hit,
  input  logic [7:0]            rd_byte,
  output logic                  bw_en,
  output logic                  lw_en,
  output logic [(8<<OFF_W)-1:0] fill_line
);
  localparam int LINE_W = 8 << OFF_W;
  localparam logic [OFF_W-1:0] LAST = '1;

  cache_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [7:0]        wdata_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [LINE_W-1:0] fill_q;
  logic [7:0]        rdata_q;

  wire idle_req = (state_q == ST_IDLE) && req_valid;
  wire fill_done = (state_q == ST_FILL) && mem_ready && (cnt_q == LAST);

  always_comb begin
    fill_line = fill_q;
    fill_line[{cnt_q, 3'b000} +: 8] = mem_rdata;
  end

  assign lk_addr   = (state_q == ST_IDLE) ? req_addr : addr_q;
  assign bw_en     = idle_req && req_write && hit;
  assign lw_en     = fill_done;
  assign req_ready = (state_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign mem_valid = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_write = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_FILL) ? {addr_q[ADDR_W-1:OFF_W], cnt_q} : addr_q;
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      cnt_q   <= '0;
      fill_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          cnt_q   <= '0;
          if (req_write) state_q <= ST_WRITE;
          else if (hit) begin
            rdata_q <= rd_byte;
            state_q <= ST_RESP;
          end else state_q <= ST_FILL;
        end
        ST_FILL: if (mem_ready) begin
          fill_q <= fill_line;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            rdata_q <= fill_line[{addr_q[OFF_W-1:0], 3'b000} +: 8];
            state_q <= ST_RESP;
          end
        end
        ST_WRITE: if (mem_ready) state_q <= ST_RESP;
        ST_RESP:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R9: a stalled memory transfer keeps its fields
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_write) && $stable(mem_wdata)));

  // R3: fill reads walk the block in ascending offset order
  p_fill_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_write && (mem_addr[OFF_W-1:0] != LAST))
    |=> (mem_valid && !mem_write
         && (mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1))
         && (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))));

  // R6: a write completes only after its memory write was accepted
  p_write_thru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && wr_q) |-> $past(mem_valid && mem_ready && mem_write));
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic [7:0]        rsp_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ready,
  input  logic [7:0]        mem_rdata
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = 8 << OFF_W;

  logic [ADDR_W-1:0] lk_addr;
  logic              hit, bw_en, lw_en;
  logic [7:0]        rd_byte;
  logic [LINE_W-1:0] fill_line;

  cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .lk_addr(lk_addr), .hit(hit), .rd_byte(rd_byte),
    .bw_en(bw_en), .lw_en(lw_en), .fill_line(fill_line)
  );

  cache_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .idx(lk_addr[OFF_W +: IDX_W]), .tag(lk_addr[ADDR_W-1 -: TAG_W]),
    .inst_en(lw_en), .hit(hit)
  );

  cache_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk(clk), .idx(lk_addr[OFF_W +: IDX_W]), .off(lk_addr[OFF_W-1:0]),
    .rd_byte(rd_byte), .bw_en(bw_en), .bw_data(req_wdata),
    .lw_en(lw_en), .lw_data(fill_line)
  );
endmodule

// File: tb/dm_wt_cache_test.sv
module dm_wt_cache_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rsp_rdata;
  logic        mem_valid, mem_write;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ready = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int n_checks = 0, n_fail = 0;
  int n_mwr = 0;
  int lat = 0, lat_seed = 0;
  logic [19:0] last_wa;
  logic [7:0]  last_wd;
  logic [19:0] fetch_log[$];
  logic [7:0]  sb[$];
  logic [7:0]  ref_mem[int];

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_wt_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mval(logic [19:0] a);
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ {1'b0, a[19:13]};
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // memory model with rotating 0..2 cycle stretch
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      lat = 0;
    end else if (mem_ready) mem_ready = 1'b0;
    else if (mem_valid) begin
      if (lat == 0) begin
        mem_ready = 1'b1;
        if (mem_write) begin
          n_mwr++;
          last_wa = mem_addr;
          last_wd = mem_wdata;
        end else begin
          mem_rdata = mval(mem_addr);
          fetch_log.push_back(mem_addr);
        end
        lat_seed = (lat_seed + 1) % 3;
        lat = lat_seed;
      end else lat--;
    end
  end

  // scoreboard monitor: read results
  always @(negedge clk) begin
    if (rst_n && req_ready && !req_write) begin
      if (sb.size() == 0) chk(1'b0, "R3/R4", "unexpected read completion", 0, 1);
      else begin
        logic [7:0] e;
        e = sb.pop_front();
        chk(rsp_rdata == e, "R3/R4/R7", "read byte", rsp_rdata, e);
      end
    end
  end

  task automatic wait_ready(output int cyc);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (req_ready) break;
      if (cyc > 200) begin
        chk(1'b0, "R9", "request never completed", cyc, 0);
        break;
      end
    end
  endtask

  task automatic end_req();
    @(negedge clk);
    chk(!req_ready, "R9", "ready longer than one cycle", req_ready, 0);
    req_valid = 1'b0;
  endtask

  task automatic do_read(logic [19:0] a, bit exp_hit, string rq);
    int cyc, w0;
    bit ok;
    fetch_log.delete();
    w0 = n_mwr;
    sb.push_back(mval(a));
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    wait_ready(cyc);
    if (exp_hit) begin
      chk(cyc == 1, rq, "hit latency", cyc, 1);
      chk(fetch_log.size() == 0, rq, "hit memory reads", fetch_log.size(), 0);
    end else begin
      chk(fetch_log.size() == 8, rq, "miss fetch count", fetch_log.size(), 8);
      ok = (fetch_log.size() == 8);
      for (int i = 0; i < 8 && ok; i++)
        if (fetch_log[i] != {a[19:3], 3'(i)}) ok = 1'b0;
      chk(ok, rq, "fetch address order", ok ? 1 : 0, 1);
    end
    chk(n_mwr == w0, rq, "memory writes during read", n_mwr - w0, 0);
    end_req();
  endtask

  task automatic do_write(logic [19:0] a, logic [7:0] d, string rq);
    int cyc, w0;
    fetch_log.delete();
    w0 = n_mwr;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    wait_ready(cyc);
    chk(n_mwr == w0 + 1, rq, "memory write count", n_mwr - w0, 1);
    chk(last_wa == a && last_wd == d, rq, "memory write addr/data",
        {last_wa, last_wd}, {a, d});
    chk(fetch_log.size() == 0, rq, "reads during write", fetch_log.size(), 0);
    ref_mem[int'(a)] = d;
    end_req();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!req_ready && !mem_valid, "R2", "reset outputs", {req_ready, mem_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_read(20'h00000, 1'b0, "R2");
    do_read(20'h00005, 1'b1, "R4");
    do_read(20'hABCDE, 1'b0, "R1");
    do_read(20'hABCD9, 1'b1, "R4");
    do_read({7'h56, 10'h39B, 3'h2}, 1'b0, "R5");
    do_read(20'hABCDE, 1'b0, "R5");
    do_write(20'hABCDB, 8'h5A, "R6");
    do_read(20'hABCDB, 1'b1, "R7");
    do_write(20'h12345, 8'hC3, "R6");
    do_read(20'h12345, 1'b0, "R8");
    do_read(20'h12341, 1'b1, "R8");
    for (int i = 0; i < 6; i++) begin
      do_read(20'h40000 + 20'(i * 8 * 37) + 20'(i), 1'b0, "R3");
      do_read(20'h40000 + 20'(i * 8 * 37) + 20'(7 - i), 1'b1, "R4");
    end
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R3", "pending scoreboard entries", sb.size(), 0);
    finish_run();
  end
endmodule